// File: doc/BRIEF.md
# Capture-to-Coprocessor Frame Relay Sequencer

This block is the control sequencer on the programmable-logic side of a video pipeline. It gates preprocessed pixel words from a capture path into an outbound FIFO, which a processing coprocessor drains. While enough data is waiting in that FIFO, the block holds a DMA request to the coprocessor. When the coprocessor signals through an interrupt that a compressed frame is ready, the block moves that frame from an inbound FIFO into the write buffer of a host-link controller. The transfer is paced by the buffer's full flag.

The frame length is a programmable word count. After each frame, the block samples an encode-valid input. If it is valid, the block carries on with the next frame. If not, it pulses an end notification to the coprocessor and returns to idle until a new capture command arrives. Both FIFOs are plain synchronous first-word-fall-through FIFOs inside the block.

Top module: `frame_relay_seq`

## Requirements
- R1: After reset the block is idle, and pixel words presented on `pixValid`/`pixData` are discarded. A one-cycle `captureCmd` makes the block accept pixel words from the next clock on. It keeps accepting them in every state except idle.
- R2: `copData` always shows the oldest word held in the outbound FIFO. A `copRd` strobe while the FIFO is not empty removes that word. Words leave in the order they were accepted.
- R3: `dmaReq` is high exactly while the outbound FIFO holds at least OUT_DEPTH/2 words, so it is a level and not a per-word pulse.
- R4: `copIrq` passes through a two-flop synchronizer. Only its rising edge, seen while the block is filling, starts a drain. An interrupt held high starts one drain, and interrupts seen in other states are ignored.
- R5: While draining, in every cycle where the inbound FIFO is not empty and `hostFull` is low, `hostWr` is high and `hostData` carries the oldest inbound byte, which is removed.
- R6: While `hostFull` is high, `hostWr` stays low and no inbound byte is removed.
- R7: A drain ends after exactly `frameLen` bytes (`frameLen` >= 1) have been written to the host buffer. Further bytes wait for the next drain.
- R8: In the cycle after the last byte of a frame, the block samples `encodeValid`. If it is high, the block returns to filling. If it is low, `endPulse` is high for that one cycle and the block goes idle.
- R9: A pixel word that arrives while the outbound FIFO is full is dropped, and the stored words are kept. `ovfErr` then goes high and stays high until reset.
- R10: During and right after reset, `dmaReq`, `hostWr`, `endPulse` and `ovfErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| captureCmd | input | 1 | Start-of-session command |
| pixValid | input | 1 | Pixel word valid |
| pixData | input | PIX_W | Preprocessed pixel word |
| copRd | input | 1 | Coprocessor read strobe, outbound FIFO |
| copData | output | PIX_W | Oldest outbound word |
| dmaReq | output | 1 | DMA request to the coprocessor |
| copWr | input | 1 | Coprocessor write strobe, inbound FIFO |
| copWrData | input | BYTE_W | Compressed byte from the coprocessor |
| copIrq | input | 1 | Asynchronous frame-ready interrupt |
| frameLen | input | LEN_W | Compressed frame length in bytes |
| hostFull | input | 1 | Host-link buffer full |
| hostWr | output | 1 | Host-link buffer write strobe |
| hostData | output | BYTE_W | Byte written to the host-link buffer |
| encodeValid | input | 1 | Continue-session flag, sampled per frame |
| endPulse | output | 1 | End-of-session notification |
| ovfErr | output | 1 | Sticky outbound overflow flag |

## Verification
The bench builds both FIFOs with eight entries, so the half-full threshold sits at four words and a short burst of writes without reads overflows the outbound side. `frameLen` is set to five while seven bytes are waiting, which shows that leftover bytes stay queued until a second interrupt drains them. With these small values, the full session is reachable in a few hundred cycles. That session covers the idle discard, the level request, throttled draining, a continue decision, a terminate decision and an interrupt ignored in idle.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_DECIDE = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptPix;
    logic inPop;
  } ctrlStrobe_t;
endpackage

// File: rtl/frs_fifo.sv
module frs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          pushOk, popOk;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(pushOk) - CW'(popOk);
    end
  end

  // R9: a write into a full FIFO with no read leaves it full, no wrap
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == CW'(DEPTH)));
  // R2: a read from a non-empty FIFO without a write lowers the count by one
  a_r2_pop_count: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/frs_datapath.sv
module frs_datapath
  import frs_pkg::*;
#(
  parameter int PIX_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixData,
  input  logic              copRd,
  output logic [PIX_W-1:0]  copData,
  input  logic              copWr,
  input  logic [BYTE_W-1:0] copWrData,
  output logic [BYTE_W-1:0] hostData,
  output logic              inEmpty,
  output logic              dmaReq,
  output logic              ovfErr
);
  localparam int OCW = $clog2(OUT_DEPTH + 1);
  localparam int ICW = $clog2(IN_DEPTH + 1);
  localparam logic [OCW-1:0] HALF_MARK = OCW'(OUT_DEPTH / 2);

  logic           outPush, outFull, outEmpty;
  logic [OCW-1:0] outCount;
  logic           inFull;
  logic [ICW-1:0] inCount;

  assign outPush = strobe.acceptPix && pixValid;

  frs_fifo #(.W(PIX_W), .DEPTH(OUT_DEPTH)) uOutFifo (
    .clk(clk), .rstN(rstN), .push(outPush), .wdata(pixData),
    .pop(copRd), .rdata(copData), .full(outFull), .empty(outEmpty),
    .count(outCount)
  );

  frs_fifo #(.W(BYTE_W), .DEPTH(IN_DEPTH)) uInFifo (
    .clk(clk), .rstN(rstN), .push(copWr), .wdata(copWrData),
    .pop(strobe.inPop), .rdata(hostData), .full(inFull), .empty(inEmpty),
    .count(inCount)
  );

  assign dmaReq = (outCount >= HALF_MARK);

  always_ff @(posedge clk) begin
    if (!rstN)                    ovfErr <= 1'b0;
    else if (outPush && outFull)  ovfErr <= 1'b1;
  end

  // R9: overflow flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr);
  // R3: an empty outbound FIFO never requests DMA
  a_r3_no_req_empty: assert property (@(posedge clk) disable iff (!rstN)
    outEmpty |-> !dmaReq);
  // R6: the control never pops an empty inbound FIFO
  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inPop |-> (inCount != '0));
endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import frs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             captureCmd,
  input  logic             copIrq,
  input  logic             encodeValid,
  input  logic             hostFull,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             inEmpty,
  output ctrlStrobe_t      strobe,
  output logic             hostWr,
  output logic             endPulse
);
  seqState_t        state;
  logic             irqMeta, irqSync, irqLast, irqRise;
  logic [LEN_W-1:0] byteCnt;
  logic             popNow, lastByte;

  assign irqRise  = irqSync && !irqLast;
  assign popNow   = (state == ST_DRAIN) && !inEmpty && !hostFull;
  assign lastByte = (byteCnt == frameLen - 1'b1);

  assign strobe.acceptPix = (state != ST_IDLE);
  assign strobe.inPop     = popNow;
  assign hostWr           = popNow;
  assign endPulse         = (state == ST_DECIDE) && !encodeValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqMeta <= 1'b0;
      irqSync <= 1'b0;
      irqLast <= 1'b0;
    end else begin
      irqMeta <= copIrq;
      irqSync <= irqMeta;
      irqLast <= irqSync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (captureCmd) state <= ST_FILL;
        ST_FILL:  if (irqRise) begin
                    state   <= ST_DRAIN;
                    byteCnt <= '0;
                  end
        ST_DRAIN: if (popNow) begin
                    if (lastByte) state <= ST_DECIDE;
                    else          byteCnt <= byteCnt + 1'b1;
                  end
        ST_DECIDE: state <= encodeValid ? ST_FILL : ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R6: no host write while the buffer is full
  a_r6_hold_full: assert property (@(posedge clk) disable iff (!rstN)
    hostFull |-> !hostWr);
  // R4: a synchronized rising edge while filling starts a drain
  a_r4_irq_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && irqRise) |=> (state == ST_DRAIN));
  // R8: the end notification lasts one cycle and leads to idle
  a_r8_end_single: assert property (@(posedge clk) disable iff (!rstN)
    endPulse |=> (!endPulse && state == ST_IDLE));
  // R1: idle holds until a capture command
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !captureCmd) |=> (state == ST_IDLE));
endmodule

// File: rtl/frame_relay_seq.sv
module frame_relay_seq
  import frs_pkg::*;
#(
  parameter int PIX_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 16,
  parameter int LEN_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              captureCmd,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixData,
  input  logic              copRd,
  output logic [PIX_W-1:0]  copData,
  output logic              dmaReq,
  input  logic              copWr,
  input  logic [BYTE_W-1:0] copWrData,
  input  logic              copIrq,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              hostFull,
  output logic              hostWr,
  output logic [BYTE_W-1:0] hostData,
  input  logic              encodeValid,
  output logic              endPulse,
  output logic              ovfErr
);
  ctrlStrobe_t strobe;
  logic        inEmpty;

  frs_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .captureCmd(captureCmd), .copIrq(copIrq),
    .encodeValid(encodeValid), .hostFull(hostFull), .frameLen(frameLen),
    .inEmpty(inEmpty), .strobe(strobe), .hostWr(hostWr), .endPulse(endPulse)
  );

  frs_datapath #(.PIX_W(PIX_W), .BYTE_W(BYTE_W), .OUT_DEPTH(OUT_DEPTH),
                 .IN_DEPTH(IN_DEPTH)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixValid(pixValid),
    .pixData(pixData), .copRd(copRd), .copData(copData), .copWr(copWr),
    .copWrData(copWrData), .hostData(hostData), .inEmpty(inEmpty),
    .dmaReq(dmaReq), .ovfErr(ovfErr)
  );
endmodule

// File: tb/tb_frame_relay_seq.sv
`timescale 1ns/1ps
module tb_frame_relay_seq;
  localparam int PW = 16, BW = 8, OD = 8, ID = 8, LW = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic captureCmd = 0, pixValid = 0, copRd = 0, copWr = 0, copIrq = 0;
  logic hostFull = 0, encodeValid = 0;
  logic [PW-1:0] pixData = '0;
  logic [BW-1:0] copWrData = '0;
  logic [LW-1:0] frameLen = LW'(5);
  logic [PW-1:0] copData;
  logic [BW-1:0] hostData;
  logic dmaReq, hostWr, endPulse, ovfErr;

  always #2.5 clk = ~clk;

  frame_relay_seq #(.PIX_W(PW), .BYTE_W(BW), .OUT_DEPTH(OD), .IN_DEPTH(ID),
                    .LEN_W(LW)) dut (.*);

  int checks = 0, fails = 0;
  int hostWrCount = 0, endCount = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mState = 0;                 // 0 idle, 1 fill, 2 drain, 3 decide
  int outQ[$], inQ[$];
  int mCnt = 0;
  bit mOvf = 0, s1 = 0, s2 = 0, s3 = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      mState = 0; outQ.delete(); inQ.delete(); mCnt = 0; mOvf = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit expPop, expEnd, rise, outFullM, inFullM, outHad;
      expPop = (mState == 2) && (inQ.size() > 0) && !hostFull;
      expEnd = (mState == 3) && !encodeValid;
      check(dmaReq == (outQ.size() >= OD/2), "R3 dmaReq", dmaReq, outQ.size() >= OD/2);
      if (outQ.size() > 0) check(copData == PW'(outQ[0]), "R2 copData", copData, outQ[0]);
      check(hostWr == expPop, "R5 hostWr", hostWr, expPop);
      if (expPop) check(hostData == BW'(inQ[0]), "R5 hostData", hostData, inQ[0]);
      check(endPulse == expEnd, "R8 endPulse", endPulse, expEnd);
      check(ovfErr == mOvf, "R9 ovfErr", ovfErr, mOvf);
      if (hostWr) hostWrCount++;
      if (endPulse) endCount++;
      // step, as the next rising edge will
      rise = s2 && !s3; s3 = s2; s2 = s1; s1 = copIrq;
      outFullM = (outQ.size() == OD);
      inFullM  = (inQ.size() == ID);
      outHad   = (outQ.size() > 0);
      if (outHad && copRd) void'(outQ.pop_front());
      if (mState != 0 && pixValid) begin
        if (outFullM) mOvf = 1; else outQ.push_back(int'(pixData));
      end
      if (expPop) void'(inQ.pop_front());
      if (copWr && !inFullM) inQ.push_back(int'(copWrData));
      case (mState)
        0: if (captureCmd) mState = 1;
        1: if (rise) begin mState = 2; mCnt = 0; end
        2: if (expPop) begin
             if (mCnt == int'(frameLen) - 1) mState = 3; else mCnt++;
           end
        default: mState = encodeValid ? 1 : 0;
      endcase
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    tick(3);
    rstN = 1;
    @(negedge clk); #0.5;
    check(!dmaReq && !hostWr && !endPulse && !ovfErr, "R10 reset outputs",
          {dmaReq, hostWr, endPulse, ovfErr}, 0);
    // idle: pixels discarded
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++) begin pixValid = 1; pixData = PW'(100 + i); tick(1); end
    pixValid = 0;
    @(negedge clk); #0.5;
    check(!dmaReq, "R1 idle discards pixels", dmaReq, 0);
    @(posedge clk); #1;
    captureCmd = 1; tick(1); captureCmd = 0;
    for (int i = 0; i < 6; i++) begin pixValid = 1; pixData = PW'(200 + i); tick(1); end
    pixValid = 0;
    @(negedge clk); #0.5;
    check(dmaReq, "R3 request at half full", dmaReq, 1);
    check(copData == PW'(200), "R1 first accepted word", copData, 200);
    @(posedge clk); #1;
    copRd = 1; tick(3); copRd = 0;
    @(negedge clk); #0.5;
    check(!dmaReq, "R3 request drops below half", dmaReq, 0);
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++) begin pixValid = 1; pixData = PW'(300 + i); tick(1); end
    pixValid = 0;
    @(negedge clk); #0.5;
    check(ovfErr, "R9 overflow flagged", ovfErr, 1);
    @(posedge clk); #1;
    copRd = 1; tick(8); copRd = 0;
    @(negedge clk); #0.5;
    check(ovfErr, "R9 flag sticky", ovfErr, 1);
    // first compressed frame: 7 bytes queued, frame of 5
    @(posedge clk); #1;
    for (int i = 0; i < 7; i++) begin copWr = 1; copWrData = BW'(8'h30 + i); tick(1); end
    copWr = 0; encodeValid = 1; hostFull = 1; copIrq = 1;
    tick(8);
    check(hostWrCount == 0, "R6 full buffer blocks writes", hostWrCount, 0);
    for (int i = 0; i < 6; i++) begin hostFull = (i % 2 == 0); tick(1); end
    hostFull = 0;
    tick(20);
    check(hostWrCount == 5, "R7 one frame of bytes", hostWrCount, 5);
    check(endCount == 0, "R8 continue without end", endCount, 0);
    // second frame after a new interrupt edge, then terminate
    copIrq = 0; encodeValid = 0;
    for (int i = 0; i < 3; i++) begin copWr = 1; copWrData = BW'(8'h50 + i); tick(1); end
    copWr = 0;
    tick(2);
    copIrq = 1; tick(2); copIrq = 0;
    tick(20);
    check(hostWrCount == 10, "R4 second drain", hostWrCount, 10);
    check(endCount == 1, "R8 end pulse once", endCount, 1);
    // idle again: interrupt ignored
    for (int i = 0; i < 5; i++) begin copWr = 1; copWrData = BW'(8'h70 + i); tick(1); end
    copWr = 0;
    copIrq = 1; tick(3); copIrq = 0; tick(10);
    check(hostWrCount == 10, "R4 interrupt ignored in idle", hostWrCount, 10);
    finish_run();
  end
endmodule